// File: doc/BRIEF.md
# ATA Programmed-I/O Cycle Sequencer

This block runs programmed-I/O register cycles on a parallel ATA drive cable. A host side presents one request at a time over a valid/ready port. Each request carries the register offset, which of the two register blocks to select, read or write, the write data and the drive the access belongs to. The sequencer drives the 3-bit register address, two active-low block selects and the active-low read and write strobes. It holds write data on the cable and returns captured read data on a one-cycle response.

Each access moves through up to four phases, all counted in host clocks. The setup phase puts address and select on the cable before any strobe goes active. The strobe phase asserts the read or write strobe. The recovery phase keeps the minimum cycle period after the strobe. The shutdown phase releases the selects. Each of the two drives has its own fast-timing enable and its own 2-bit strobe and recovery fields. Fast timing applies only to data-port accesses. Every other access uses a fixed, slow compatible timing that always sets up and shuts down. Two fast data-port accesses in a row can run back-to-back, with no setup phase between them.

Top module: `ata_pio_seq`

## Requirements
- R1: After reset, both selects are high (`ata_cs_n` = 2'b11), both strobes are high, `rsp_valid` is low and `req_ready` is high.
- R2: During an access, `req_cs_sel` = 0 drives `ata_cs_n` = 2'b10 and `req_cs_sel` = 1 drives `ata_cs_n` = 2'b01. `ata_addr` carries `req_addr` for the whole access. Neither strobe goes low while both selects are high.
- R3: Fast timing is used only when the bit `cfg_fast_en[d]` of the addressed drive d is set and the target is the data port (`req_cs_sel` = 0, `req_addr` = 0). Every other access uses compatible timing.
- R4: Under fast timing, the strobe stays low for `cfg_strobe_sel[2d+1:2d]` + 2 clocks, which is 2 to 5 clocks.
- R5: Under fast timing, recovery lasts `cfg_recov_sel[2d+1:2d]` + 1 clocks, which is 1 to 4 clocks.
- R6: Compatible timing uses 3 setup clocks, a 5-clock strobe and 4 recovery clocks.
- R7: A fast access that starts from idle has exactly 1 setup clock, with the selects active and both strobes high.
- R8: `req_ready` is high only when the sequencer is idle, or in the final recovery clock of a fast access. It is never high during a strobe.
- R9: A fast data-port request accepted in the final recovery clock of a fast access to the same target starts its strobe on the next clock, with no setup. If the new request is to another target, or uses compatible timing, its setup phase runs immediately after recovery and the selects stay active throughout.
- R10: When recovery ends with no request accepted, the selects stay active for exactly one more clock with both strobes high, then go to 2'b11.
- R11: For a read, `ata_din` is sampled on the last clock of the strobe. It appears on `rsp_rdata` with `rsp_valid` high for exactly one clock, the clock after the strobe ends.
- R12: For a write, `ata_dout_en` is high and `ata_dout` equals the write data from the first setup clock through the last recovery clock. `ata_rd_n` never goes low on a write, `ata_wr_n` never goes low on a read, and the two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock; all timing is counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can take a request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs_sel | input | 1 | Register block: 0 = command block, 1 = control block |
| req_addr | input | 3 | Register offset within the block |
| req_drive | input | 1 | Drive the access is timed for |
| req_wdata | input | 16 | Write data |
| cfg_fast_en | input | 2 | Fast-timing enable, one bit per drive |
| cfg_strobe_sel | input | 4 | Fast strobe-width field, 2 bits per drive |
| cfg_recov_sel | input | 4 | Fast recovery field, 2 bits per drive |
| ata_addr | output | 3 | Register address on the cable |
| ata_cs_n | output | 2 | Active-low block selects |
| ata_rd_n | output | 1 | Active-low read strobe |
| ata_wr_n | output | 1 | Active-low write strobe |
| ata_dout | output | 16 | Write data toward the cable |
| ata_dout_en | output | 1 | Data bus output enable |
| ata_din | input | 16 | Read data from the cable |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Captured read data |

## Verification
The bench measures the setup, strobe and recovery-plus-shutdown lengths of every access. It uses random per-drive configurations and random targets, so a timing selector that ignored the drive bit or the data-port restriction would produce wrong phase lengths. Directed back-to-back pairs cover a same-target fast follow-up, a follow-up to another register, a follow-up whose drive has fast timing off, and a compatible pair. A design that skipped setup too eagerly would show a gap equal to recovery alone where setup belongs, and one that dropped out to idle would break the selects between the strobes. The cable read data is valid only while the read strobe is low, so a read captured one clock late returns a marker value instead of the pattern. Counting output-enable clocks exposes a write bus window that is too short or too long.

// File: rtl/ata_pio_pkg.sv
// Shared types for the PIO cycle sequencer.
// Assumes every phase length fits in CNT_W bits once reduced by one.
package ata_pio_pkg;

    localparam int CNT_W = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_RECOV,
        PH_SHUT
    } phase_e;

    // Phase lengths are stored minus one so a down-counter ends at zero.
    typedef struct packed {
        logic fast;
        cnt_t setup_m1;
        cnt_t strobe_m1;
        cnt_t recov_m1;
    } timing_t;

endpackage

// File: rtl/ata_pio_timing_sel.sv
// Picks the phase lengths for an incoming request.
// Fast timing applies only when the drive's enable is set and the target is
// the data port. Everything else gets the fixed compatible timing.
// Purely combinational; assumes FAST_SETUP >= 1 and all lengths <= 2**CNT_W.
module ata_pio_timing_sel
    import ata_pio_pkg::*;
#(
    parameter int NUM_DRV       = 2,
    parameter int DRV_W         = 1,
    parameter int ADDR_W        = 3,
    parameter int CS_W          = 1,
    parameter int SEL_W         = 2,
    parameter int DATA_ADDR     = 0,
    parameter int FAST_SETUP    = 1,
    parameter int FAST_STB_MIN  = 2,
    parameter int FAST_REC_MIN  = 1,
    parameter int COMPAT_SETUP  = 3,
    parameter int COMPAT_STROBE = 5,
    parameter int COMPAT_RECOV  = 4
) (
    input  logic [DRV_W-1:0]         drive,
    input  logic [CS_W-1:0]          cs_sel,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NUM_DRV-1:0]       fast_en,
    input  logic [SEL_W*NUM_DRV-1:0] strobe_sel,
    input  logic [SEL_W*NUM_DRV-1:0] recov_sel,
    output timing_t                  timing
);

    logic [NUM_DRV-1:0] drv_hit;
    logic               is_data_port;
    logic               drv_fast;
    logic [SEL_W-1:0]   stb_field;
    logic [SEL_W-1:0]   rec_field;

    // One decode line per drive
    genvar g;
    generate
        for (g = 0; g < NUM_DRV; g++) begin : g_drv
            assign drv_hit[g] = (drive == DRV_W'(g));
        end
    endgenerate

    // Gather the fields of the addressed drive
    always_comb begin
        drv_fast  = 1'b0;
        stb_field = '0;
        rec_field = '0;
        for (int d = 0; d < NUM_DRV; d++) begin
            if (drv_hit[d]) begin
                drv_fast  = fast_en[d];
                stb_field = strobe_sel[d*SEL_W +: SEL_W];
                rec_field = recov_sel[d*SEL_W +: SEL_W];
            end
        end
    end

    assign is_data_port = (cs_sel == '0) && (addr == ADDR_W'(DATA_ADDR));

    // Build the timing record for the chosen mode
    always_comb begin
        if (drv_fast && is_data_port) begin
            timing.fast      = 1'b1;
            timing.setup_m1  = cnt_t'(FAST_SETUP - 1);
            timing.strobe_m1 = cnt_t'(stb_field) + cnt_t'(FAST_STB_MIN - 1);
            timing.recov_m1  = cnt_t'(rec_field) + cnt_t'(FAST_REC_MIN - 1);
        end else begin
            timing.fast      = 1'b0;
            timing.setup_m1  = cnt_t'(COMPAT_SETUP - 1);
            timing.strobe_m1 = cnt_t'(COMPAT_STROBE - 1);
            timing.recov_m1  = cnt_t'(COMPAT_RECOV - 1);
        end
    end

endmodule

// File: rtl/ata_pio_phase_ctl.sv
// Phase sequencer: idle, setup, strobe, recovery, shutdown.
// Accepts a request when idle, or in the last recovery clock of a fast
// access. A fast follow-up to the same target goes straight to the strobe.
// Assumes the timing record is valid whenever req_valid is high.
module ata_pio_phase_ctl
    import ata_pio_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  timing_t new_timing,
    input  logic    same_target,
    output logic    req_ready,
    output logic    accept,
    output phase_e  phase,
    output logic    strobe_last
);

    phase_e  phase_q;
    cnt_t    cnt_q;
    timing_t cur_q;
    logic    recov_last;
    logic    skip_setup;

    // Decode end-of-phase conditions and the host handshake
    always_comb begin
        recov_last  = (phase_q == PH_RECOV) && (cnt_q == '0);
        strobe_last = (phase_q == PH_STROBE) && (cnt_q == '0);
        req_ready   = (phase_q == PH_IDLE) || (recov_last && cur_q.fast);
        accept      = req_valid && req_ready;
        skip_setup  = recov_last && cur_q.fast && new_timing.fast && same_target;
    end

    // Phase register and down-counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            cur_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= new_timing.setup_m1;
                        cur_q   <= new_timing;
                    end
                end
                PH_SETUP: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_STROBE;
                        cnt_q   <= cur_q.strobe_m1;
                    end else begin
                        cnt_q <= cnt_q - cnt_t'(1);
                    end
                end
                PH_STROBE: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_RECOV;
                        cnt_q   <= cur_q.recov_m1;
                    end else begin
                        cnt_q <= cnt_q - cnt_t'(1);
                    end
                end
                PH_RECOV: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - cnt_t'(1);
                    end else if (accept) begin
                        cur_q <= new_timing;
                        if (skip_setup) begin
                            phase_q <= PH_STROBE;
                            cnt_q   <= new_timing.strobe_m1;
                        end else begin
                            phase_q <= PH_SETUP;
                            cnt_q   <= new_timing.setup_m1;
                        end
                    end else begin
                        phase_q <= PH_SHUT;
                    end
                end
                PH_SHUT: begin
                    phase_q <= PH_IDLE;
                end
                default: begin
                    phase_q <= PH_IDLE;
                end
            endcase
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/ata_pio_datapath.sv
// Cable-side datapath: holds the target and write data of the current
// access, decodes selects and strobes from the phase, and captures read
// data on the last strobe clock. Assumes phase comes from ata_pio_phase_ctl.
module ata_pio_datapath
    import ata_pio_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int NUM_CS = 2,
    parameter int CS_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs_sel,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_e            phase,
    input  logic              strobe_last,
    input  logic [DATA_W-1:0] ata_din,
    output logic              same_target,
    output logic [ADDR_W-1:0] ata_addr,
    output logic [NUM_CS-1:0] ata_cs_n,
    output logic              ata_rd_n,
    output logic              ata_wr_n,
    output logic [DATA_W-1:0] ata_dout,
    output logic              ata_dout_en,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic              write_q;
    logic [CS_W-1:0]   cs_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              active;
    logic              in_strobe;

    // Latch the target and write data of each accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            cs_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            write_q <= req_write;
            cs_q    <= req_cs_sel;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture read data at the edge that ends the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= strobe_last && !write_q;
            if (strobe_last && !write_q) begin
                rsp_rdata <= ata_din;
            end
        end
    end

    // Decode cable controls from the phase
    always_comb begin
        active      = (phase != PH_IDLE);
        in_strobe   = (phase == PH_STROBE);
        ata_rd_n    = !(in_strobe && !write_q);
        ata_wr_n    = !(in_strobe && write_q);
        ata_dout_en = write_q && ((phase == PH_SETUP) || in_strobe || (phase == PH_RECOV));
        same_target = (req_cs_sel == cs_q) && (req_addr == addr_q);
    end

    // One active-low select per register block
    genvar c;
    generate
        for (c = 0; c < NUM_CS; c++) begin : g_cs
            assign ata_cs_n[c] = !(active && (cs_q == CS_W'(c)));
        end
    endgenerate

    assign ata_addr = addr_q;
    assign ata_dout = wdata_q;

endmodule

// File: rtl/ata_pio_seq.sv
// Top of the ATA programmed-I/O cycle sequencer.
// Joins the timing selector, the phase sequencer and the cable datapath.
// Assumes the configuration inputs are static while accesses run.
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int NUM_DRV       = 2,
    parameter int ADDR_W        = 3,
    parameter int DATA_W        = 16,
    parameter int NUM_CS        = 2,
    parameter int SEL_W         = 2,
    parameter int DATA_ADDR     = 0,
    parameter int FAST_SETUP    = 1,
    parameter int COMPAT_SETUP  = 3,
    parameter int COMPAT_STROBE = 5,
    parameter int COMPAT_RECOV  = 4,
    localparam int DRV_W        = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1,
    localparam int CS_W         = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [CS_W-1:0]          req_cs_sel,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DRV_W-1:0]         req_drive,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [NUM_DRV-1:0]       cfg_fast_en,
    input  logic [SEL_W*NUM_DRV-1:0] cfg_strobe_sel,
    input  logic [SEL_W*NUM_DRV-1:0] cfg_recov_sel,
    output logic [ADDR_W-1:0]        ata_addr,
    output logic [NUM_CS-1:0]        ata_cs_n,
    output logic                     ata_rd_n,
    output logic                     ata_wr_n,
    output logic [DATA_W-1:0]        ata_dout,
    output logic                     ata_dout_en,
    input  logic [DATA_W-1:0]        ata_din,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata
);

    timing_t new_timing;
    logic    same_target;
    logic    accept;
    logic    strobe_last;
    phase_e  phase;

    ata_pio_timing_sel #(
        .NUM_DRV      (NUM_DRV),
        .DRV_W        (DRV_W),
        .ADDR_W       (ADDR_W),
        .CS_W         (CS_W),
        .SEL_W        (SEL_W),
        .DATA_ADDR    (DATA_ADDR),
        .FAST_SETUP   (FAST_SETUP),
        .FAST_STB_MIN (2),
        .FAST_REC_MIN (1),
        .COMPAT_SETUP (COMPAT_SETUP),
        .COMPAT_STROBE(COMPAT_STROBE),
        .COMPAT_RECOV (COMPAT_RECOV)
    ) u_tsel (
        .drive     (req_drive),
        .cs_sel    (req_cs_sel),
        .addr      (req_addr),
        .fast_en   (cfg_fast_en),
        .strobe_sel(cfg_strobe_sel),
        .recov_sel (cfg_recov_sel),
        .timing    (new_timing)
    );

    ata_pio_phase_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .new_timing (new_timing),
        .same_target(same_target),
        .req_ready  (req_ready),
        .accept     (accept),
        .phase      (phase),
        .strobe_last(strobe_last)
    );

    ata_pio_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .NUM_CS(NUM_CS),
        .CS_W  (CS_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_write  (req_write),
        .req_cs_sel (req_cs_sel),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .phase      (phase),
        .strobe_last(strobe_last),
        .ata_din    (ata_din),
        .same_target(same_target),
        .ata_addr   (ata_addr),
        .ata_cs_n   (ata_cs_n),
        .ata_rd_n   (ata_rd_n),
        .ata_wr_n   (ata_wr_n),
        .ata_dout   (ata_dout),
        .ata_dout_en(ata_dout_en),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

endmodule

// File: rtl/ata_pio_seq_chk.sv
// Protocol checker for ata_pio_seq, attached by bind.
// Watches only the ports. Assumes MAX_STROBE is the longest legal strobe.
module ata_pio_seq_chk #(
    parameter int NUM_CS     = 2,
    parameter int MAX_STROBE = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [NUM_CS-1:0] ata_cs_n,
    input logic              ata_rd_n,
    input logic              ata_wr_n,
    input logic              ata_dout_en,
    input logic              rsp_valid
);

    logic [3:0] strobe_run;
    logic       cs_idle;

    assign cs_idle = (ata_cs_n == '1);

    // Length of the current strobe, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_run <= '0;
        end else if (!ata_rd_n || !ata_wr_n) begin
            strobe_run <= strobe_run + 4'((strobe_run != 4'hF) ? 1 : 0);
        end else begin
            strobe_run <= '0;
        end
    end

    assert_strobe_needs_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |-> (ata_rd_n && ata_wr_n));

    assert_one_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ata_cs_n));

    assert_strobe_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_run <= 4'(MAX_STROBE));

    assert_no_ready_in_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ata_rd_n && ata_wr_n));

    assert_quiet_shutdown_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_idle ##1 cs_idle) |-> $past(ata_rd_n && ata_wr_n));

    assert_rsp_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $rose(ata_rd_n));

    assert_strobes_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_rd_n && !ata_wr_n));

    assert_write_drives_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_wr_n |-> ata_dout_en);

endmodule

bind ata_pio_seq ata_pio_seq_chk #(
    .NUM_CS(NUM_CS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .ata_cs_n   (ata_cs_n),
    .ata_rd_n   (ata_rd_n),
    .ata_wr_n   (ata_wr_n),
    .ata_dout_en(ata_dout_en),
    .rsp_valid  (rsp_valid)
);

// File: tb/ata_pio_seq_tb.sv
// Self-checking bench: random single accesses plus directed back-to-back pairs.
module ata_pio_seq_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [0:0]  req_cs_sel = '0;
    logic [2:0]  req_addr = '0;
    logic [0:0]  req_drive = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  cfg_fast_en = '0;
    logic [3:0]  cfg_strobe_sel = '0;
    logic [3:0]  cfg_recov_sel = '0;
    logic [2:0]  ata_addr;
    logic [1:0]  ata_cs_n;
    logic        ata_rd_n;
    logic        ata_wr_n;
    logic [15:0] ata_dout;
    logic        ata_dout_en;
    logic [15:0] ata_din;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] rd_pat = 16'h1234;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Cable data is only meaningful while the read strobe is low
    assign ata_din = !ata_rd_n ? rd_pat : 16'hBAD0;

    ata_pio_seq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_cs_sel    (req_cs_sel),
        .req_addr      (req_addr),
        .req_drive     (req_drive),
        .req_wdata     (req_wdata),
        .cfg_fast_en   (cfg_fast_en),
        .cfg_strobe_sel(cfg_strobe_sel),
        .cfg_recov_sel (cfg_recov_sel),
        .ata_addr      (ata_addr),
        .ata_cs_n      (ata_cs_n),
        .ata_rd_n      (ata_rd_n),
        .ata_wr_n      (ata_wr_n),
        .ata_dout      (ata_dout),
        .ata_dout_en   (ata_dout_en),
        .ata_din       (ata_din),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata)
    );

    // ---------------- monitor ----------------
    bit          chk_en = 1'b0;
    logic        exp_write;
    logic [1:0]  exp_cs_n;
    logic [2:0]  exp_addr;
    logic [15:0] exp_wdata;
    logic        prev_strobe = 1'b0;
    logic        prev_cs = 1'b0;
    logic        strobe_now;
    logic        cs_now;
    bit          seen_strobe = 1'b0;
    int run_strobe = 0, run_pre = 0, run_post = 0;
    int m_setup = -1, m_strobe = -1, m_gap = -1, m_tail = -1;
    int n_strobes = 0, n_rsp = 0, rdy_busy = 0, en_cycles = 0, bad_cyc = 0;
    logic [15:0] m_rdata = '0;

    // Measure phase lengths at every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            strobe_now = !ata_rd_n || !ata_wr_n;
            cs_now     = (ata_cs_n != 2'b11);
            if (cs_now && req_ready) rdy_busy++;
            if (ata_dout_en) en_cycles++;
            if (strobe_now) begin
                if (!prev_strobe) begin
                    if (seen_strobe) m_gap = run_post;
                    else             m_setup = run_pre;
                    run_strobe = 0;
                end
                run_strobe++;
                if (chk_en) begin
                    if (ata_cs_n != exp_cs_n || ata_addr != exp_addr) bad_cyc++;
                    if (exp_write && (!ata_rd_n || !ata_dout_en || ata_dout != exp_wdata)) bad_cyc++;
                    if (!exp_write && !ata_wr_n) bad_cyc++;
                end
            end else if (cs_now) begin
                if (prev_strobe) begin
                    m_strobe = run_strobe;
                    n_strobes++;
                    run_post = 0;
                    seen_strobe = 1'b1;
                end
                if (seen_strobe) run_post++;
                else             run_pre++;
            end else begin
                if (prev_cs) m_tail = run_post;
                seen_strobe = 1'b0;
                run_pre = 0;
                run_post = 0;
            end
            if (rsp_valid) begin
                m_rdata = rsp_rdata;
                n_rsp++;
            end
            prev_strobe = strobe_now;
            prev_cs     = cs_now;
        end
    end

    // ---------------- helpers ----------------
    task automatic check_int(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        m_setup = -1; m_strobe = -1; m_gap = -1; m_tail = -1;
        n_strobes = 0; n_rsp = 0; rdy_busy = 0; en_cycles = 0; bad_cyc = 0;
    endtask

    function automatic bit is_fast(input int d, input int cs, input int a);
        return cfg_fast_en[d] && cs == 0 && a == 0;
    endfunction
    function automatic int exp_setup(input int d, input int cs, input int a);
        return is_fast(d, cs, a) ? 1 : 3;
    endfunction
    function automatic int exp_strobe(input int d, input int cs, input int a);
        return is_fast(d, cs, a) ? int'(cfg_strobe_sel[2*d +: 2]) + 2 : 5;
    endfunction
    function automatic int exp_recov(input int d, input int cs, input int a);
        return is_fast(d, cs, a) ? int'(cfg_recov_sel[2*d +: 2]) + 1 : 4;
    endfunction

    // Present a request at a falling edge and hold it until accepted
    task automatic issue(input int d, input int cs, input int a, input bit wr, input logic [15:0] wd);
        req_valid  = 1'b1;
        req_drive  = 1'(d);
        req_cs_sel = 1'(cs);
        req_addr   = 3'(a);
        req_write  = wr;
        req_wdata  = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(ata_cs_n == 2'b11 && req_ready));
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    // One isolated access with full phase checks
    task automatic single(input int d, input int cs, input int a, input bit wr);
        int s, t, r;
        logic [15:0] wd;
        s  = exp_setup(d, cs, a);
        t  = exp_strobe(d, cs, a);
        r  = exp_recov(d, cs, a);
        wd = 16'($urandom);
        rd_pat    = 16'($urandom) | 16'h0001;
        exp_write = wr;
        exp_cs_n  = (cs == 0) ? 2'b10 : 2'b01;
        exp_addr  = 3'(a);
        exp_wdata = wd;
        clear_mon();
        chk_en = 1'b1;
        issue(d, cs, a, wr, wd);
        wait_idle();
        chk_en = 1'b0;
        check_int(is_fast(d, cs, a) ? "R7 fast setup (R3)" : "R6 compat setup (R3)", m_setup, s);
        check_int(is_fast(d, cs, a) ? "R4 fast strobe (R3)" : "R6 compat strobe (R3)", m_strobe, t);
        check_int("R5/R6 recovery plus R10 shutdown", m_tail, r + 1);
        check_int("R8 ready while selects active", rdy_busy, is_fast(d, cs, a) ? 1 : 0);
        check_int("R2/R12 target and data during strobe", bad_cyc, 0);
        check_int("R12 output enable window", en_cycles, wr ? s + t + r : 0);
        check_int("R11 response count", n_rsp, wr ? 0 : 1);
        if (!wr) check_int("R11 read data", int'(m_rdata), int'(rd_pat));
    endtask

    // Two requests presented with no idle between them
    task automatic pair(input string tag, input int d1, input int cs1, input int a1,
                        input int d2, input int cs2, input int a2, input int gap_exp, input int stb2_exp);
        rd_pat = 16'h5A5A;
        clear_mon();
        issue(d1, cs1, a1, 1'b0, 16'h0);
        issue(d2, cs2, a2, 1'b0, 16'h0);
        wait_idle();
        check_int({tag, " gap between strobes"}, m_gap, gap_exp);
        check_int({tag, " second strobe"}, m_strobe, stb2_exp);
        check_int({tag, " strobes with selects held"}, n_strobes, 2);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int seed;
        seed = int'($urandom(32'hA7A5));
        repeat (3) @(negedge clk);
        // R1: reset state
        check_int("R1 selects idle", int'(ata_cs_n), 3);
        check_int("R1 strobes high", int'({ata_rd_n, ata_wr_n}), 3);
        check_int("R1 no response", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R1 ready after reset", int'(req_ready), 1);

        // Directed singles: compatible, fast minimum, fast maximum, control block
        cfg_fast_en = 2'b01; cfg_strobe_sel = 4'b11_00; cfg_recov_sel = 4'b11_00;
        single(0, 0, 0, 1'b0);   // R3 fast, shortest
        single(1, 0, 0, 1'b1);   // R3 drive 1 not enabled: compat
        single(0, 1, 6, 1'b0);   // R2 control block, compat
        single(0, 0, 1, 1'b1);   // R3 not data port: compat
        cfg_fast_en = 2'b10;
        single(1, 0, 0, 1'b1);   // R4/R5 longest fast

        // R9 back-to-back cases
        cfg_fast_en = 2'b11; cfg_strobe_sel = 4'b11_00; cfg_recov_sel = 4'b00_11;
        pair("R9 same target fast", 0, 0, 0, 0, 0, 0, 4, 2);
        pair("R9 other drive fast", 0, 0, 0, 1, 0, 0, 4, 5);
        pair("R9 other register", 0, 0, 0, 0, 0, 7, 4 + 3, 5);
        cfg_fast_en = 2'b01;
        pair("R9 compat follow-up", 0, 0, 0, 1, 0, 0, 4 + 3, 5);

        // R10 compatible pair must drop to idle in between
        rd_pat = 16'h0F0F;
        clear_mon();
        issue(0, 0, 3, 1'b0, 16'h0);
        issue(0, 0, 3, 1'b0, 16'h0);
        wait_idle();
        check_int("R10 compat tail", m_tail, 5);
        check_int("R10 compat re-setup", m_setup, 3);
        check_int("R10 no held gap", m_gap, -1);

        // Random singles
        for (int i = 0; i < 60; i++) begin
            int d, cs, a;
            cfg_fast_en    = 2'($urandom);
            cfg_strobe_sel = 4'($urandom);
            cfg_recov_sel  = 4'($urandom);
            d  = int'($urandom % 2);
            cs = ($urandom % 4 == 0) ? 1 : 0;
            a  = ($urandom % 2 == 0) ? 0 : int'($urandom % 8);
            single(d, cs, a, 1'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule